// File: doc/BRIEF.md
# Clamping Incremental Parameter Interpolator

This block tracks one linear per-pixel quantity, such as one colour channel or depth, while a pixel traverser walks a primitive. Setup software writes a start value and two increments, one per X step and one per Y step, into shadow registers. The next primitive can be staged there while the current one is still being walked. A start pulse copies the staged set into the working registers and seeds the accumulator.

After that, a two-bit step code shared by all lanes moves the accumulator on every clock. The accumulator can step one pixel right, one pixel left or one row down, or it can stay where it is. The working value is a signed fixed-point number with guard bits above and below the output range. Pixels added only for edge smoothing lie just outside the exact primitive, so their extrapolated value can leave the legal range. The output saturates such values to the nearer limit and leaves the accumulator untouched. One result and its valid flag come out every clock. Several lanes run side by side, one per parameter.

Top module: `interp_lane`

## Requirements
- R1: While rst_ni is low, and on the first sample after it rises, value_o is 0 and vld_o is 0. The accumulator, working increments and shadow registers all clear to 0.
- R2: With wr_en_i high, wr_sel_i picks the shadow register that takes wr_data_i: 0 is the start value, 1 is the X increment and 2 is the Y increment. Code 3 writes nothing. Shadow writes do not change value_o until the next start.
- R3: start_i loads the accumulator from the shadow start value and the working increments from the shadow increments. It uses the shadow contents from before any write in the same cycle. The step code is ignored in that cycle.
- R4: Without start_i, step_i changes the accumulator as follows: 0 holds it, 1 adds the X increment, 2 subtracts the X increment and 3 adds the Y increment. Arithmetic wraps modulo 2^ACC_W.
- R5: value_o is registered and shows the accumulator after the update of the previous clock. It takes the integer part with the fraction truncated. vld_o equals vld_i of the previous clock.
- R6: When the accumulator's integer part is above 2^OUT_W-1, value_o is 2^OUT_W-1.
- R7: When the accumulator is negative, value_o is 0.
- R8: Saturation does not alter the accumulator: after stepping back into range, value_o equals the unsaturated result of all the steps taken.
- R9: A hold step with no start leaves value_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Shadow register write strobe |
| wr_sel_i | input | 2 | Shadow register select (0 start, 1 X increment, 2 Y increment) |
| wr_data_i | input | ACC_W | Signed fixed-point write data, FRAC_W fraction bits |
| start_i | input | 1 | Begin a new primitive from the shadow set |
| step_i | input | 2 | Step code (0 hold, 1 +X, 2 -X, 3 +Y) |
| vld_i | input | 1 | Current traverser pixel is valid |
| value_o | output | OUT_W | Saturated parameter value |
| vld_o | output | 1 | Valid flag aligned with value_o |

## Verification
The bound checker watches the following on every clock:
- each step code's effect on the accumulator;
- loading at start;
- the working increments staying fixed between starts;
- both saturation limits against the accumulator;
- output stability under hold;
- the valid delay.

The bench scenarios are needed to show the rest:
- that the shadow registers are isolated from a primitive in progress, including a write in the same cycle as a start;
- that the unused select code is dropped;
- that a value pushed past either limit comes back exact once the walk re-enters the range.

// File: rtl/interp_pkg.sv
package interp_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_XINC = 2'd1,
    STEP_XDEC = 2'd2,
    STEP_YINC = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_DX    = 2'd1,
    SEL_DY    = 2'd2,
    SEL_NONE  = 2'd3
  } wsel_e;
endpackage

// File: rtl/interp_shadow.sv
module interp_shadow #(
  parameter int ACC_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [ACC_W-1:0] wr_data_i,
  output logic [ACC_W-1:0] shd_start_o,
  output logic [ACC_W-1:0] shd_dx_o,
  output logic [ACC_W-1:0] shd_dy_o
);
  import interp_pkg::*;

  localparam int NREG = 3;

  logic [ACC_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == 2'(g))        regs_q[g] <= wr_data_i;
    end
  end

  assign shd_start_o = regs_q[int'(SEL_START)];
  assign shd_dx_o    = regs_q[int'(SEL_DX)];
  assign shd_dy_o    = regs_q[int'(SEL_DY)];
endmodule

// File: rtl/interp_accum.sv
module interp_accum #(
  parameter int ACC_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       step_i,
  input  logic [ACC_W-1:0] shd_start_i,
  input  logic [ACC_W-1:0] shd_dx_i,
  input  logic [ACC_W-1:0] shd_dy_i,
  output logic [ACC_W-1:0] acc_d_o,
  output logic [ACC_W-1:0] acc_q_o,
  output logic [ACC_W-1:0] act_dx_o,
  output logic [ACC_W-1:0] act_dy_o
);
  import interp_pkg::*;

  logic [ACC_W-1:0] acc_q, acc_d, dx_q, dy_q;
  step_e            step;

  assign step = step_e'(step_i);

  // load wins over any step
  always_comb begin
    acc_d = acc_q;
    if (start_i) begin
      acc_d = shd_start_i;
    end else begin
      unique case (step)
        STEP_XINC: acc_d = acc_q + dx_q;
        STEP_XDEC: acc_d = acc_q - dx_q;
        STEP_YINC: acc_d = acc_q + dy_q;
        default:   acc_d = acc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      dx_q  <= '0;
      dy_q  <= '0;
    end else begin
      acc_q <= acc_d;
      if (start_i) begin
        dx_q <= shd_dx_i;
        dy_q <= shd_dy_i;
      end
    end
  end

  assign acc_d_o  = acc_d;
  assign acc_q_o  = acc_q;
  assign act_dx_o = dx_q;
  assign act_dy_o = dy_q;
endmodule

// File: rtl/interp_clamp.sv
module interp_clamp #(
  parameter int OUT_W   = 8,
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 2,
  parameter int ACC_W   = 1 + GUARD_W + OUT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             vld_i,
  output logic [OUT_W-1:0] value_o,
  output logic             vld_o
);
  localparam int SIGN_B = ACC_W - 1;
  localparam int OVF_LO = FRAC_W + OUT_W;

  logic             neg, ovf;
  logic [OUT_W-1:0] sat;

  assign neg = acc_i[SIGN_B];

  if (GUARD_W > 0) begin : g_guard
    assign ovf = |acc_i[SIGN_B-1:OVF_LO];
  end else begin : g_noguard
    assign ovf = 1'b0;
  end

  always_comb begin
    if (neg)      sat = '0;
    else if (ovf) sat = '1;
    else          sat = acc_i[FRAC_W +: OUT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_o <= '0;
      vld_o   <= 1'b0;
    end else begin
      value_o <= sat;
      vld_o   <= vld_i;
    end
  end
endmodule

// File: rtl/interp_lane.sv
module interp_lane #(
  parameter int  OUT_W   = 8,
  parameter int  FRAC_W  = 16,
  parameter int  GUARD_W = 2,
  localparam int ACC_W   = 1 + GUARD_W + OUT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [ACC_W-1:0] wr_data_i,
  input  logic             start_i,
  input  logic [1:0]       step_i,
  input  logic             vld_i,
  output logic [OUT_W-1:0] value_o,
  output logic             vld_o
);
  logic [ACC_W-1:0] shd_start, shd_dx, shd_dy;
  logic [ACC_W-1:0] acc_d, acc_q, act_dx, act_dy;

  interp_shadow #(.ACC_W(ACC_W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .shd_start_o (shd_start),
    .shd_dx_o    (shd_dx),
    .shd_dy_o    (shd_dy)
  );

  interp_accum #(.ACC_W(ACC_W)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .step_i      (step_i),
    .shd_start_i (shd_start),
    .shd_dx_i    (shd_dx),
    .shd_dy_i    (shd_dy),
    .acc_d_o     (acc_d),
    .acc_q_o     (acc_q),
    .act_dx_o    (act_dx),
    .act_dy_o    (act_dy)
  );

  interp_clamp #(
    .OUT_W(OUT_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .ACC_W(ACC_W)
  ) u_clamp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc_d),
    .vld_i   (vld_i),
    .value_o (value_o),
    .vld_o   (vld_o)
  );
endmodule

// File: rtl/interp_lane_chk.sv
module interp_lane_chk #(
  parameter int OUT_W   = 8,
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 2,
  parameter int ACC_W   = 1 + GUARD_W + OUT_W + FRAC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       step_i,
  input logic             vld_i,
  input logic             vld_o,
  input logic [OUT_W-1:0] value_o,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] shd_start,
  input logic [ACC_W-1:0] act_dx,
  input logic [ACC_W-1:0] act_dy
);
  logic acc_neg, acc_big;
  assign acc_neg = acc_q[ACC_W-1];
  assign acc_big = !acc_q[ACC_W-1] && (acc_q[ACC_W-2:FRAC_W] > (ACC_W-1-FRAC_W)'((1 << OUT_W) - 1));

  // R3
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> acc_q == $past(shd_start));

  // R4
  step_xinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && step_i == 2'd1) |=> acc_q == (ACC_W)'($past(acc_q) + $past(act_dx)));

  // R4
  step_xdec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && step_i == 2'd2) |=> acc_q == (ACC_W)'($past(acc_q) - $past(act_dx)));

  // R4
  step_yinc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && step_i == 2'd3) |=> acc_q == (ACC_W)'($past(acc_q) + $past(act_dy)));

  // R2
  incr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(act_dx) && $stable(act_dy));

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && step_i == 2'd0) |=> $stable(value_o));

  // R5
  vld_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);

  // R5
  vld_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);

  // R7
  sat_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_neg |-> value_o == '0);

  // R6
  sat_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_big |-> value_o == '1);
endmodule

bind interp_lane interp_lane_chk #(
  .OUT_W(OUT_W), .FRAC_W(FRAC_W), .GUARD_W(GUARD_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .step_i    (step_i),
  .vld_i     (vld_i),
  .vld_o     (vld_o),
  .value_o   (value_o),
  .acc_q     (acc_q),
  .shd_start (shd_start),
  .act_dx    (act_dx),
  .act_dy    (act_dy)
);

// File: tb/tb_interp_lane.sv
module tb_interp_lane;
  localparam int OUT_W = 8, FRAC_W = 16, GUARD_W = 2;
  localparam int ACC_W = 1 + GUARD_W + OUT_W + FRAC_W;

  logic             clk = 0, rst_ni = 0;
  logic             wr_en = 0, start = 0, vld = 0;
  logic [1:0]       wr_sel = 0, step = 0;
  logic [ACC_W-1:0] wr_data = '0;
  logic [OUT_W-1:0] value_o;
  logic             vld_o;

  int    checks = 0, errors = 0;
  bit    done = 0;
  string tag = "R1";

  longint m_sh[3];
  longint m_acc = 0, m_dx = 0, m_dy = 0;
  int     exp_val = 0;
  bit     exp_vld = 0;

  always #10 clk = ~clk;

  interp_lane dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .start_i(start), .step_i(step), .vld_i(vld),
    .value_o(value_o), .vld_o(vld_o)
  );

  function automatic longint wrap(longint v);
    longint m = longint'(1) << ACC_W;
    v = v % m;
    if (v < 0) v += m;
    if (v >= (m >> 1)) v -= m;
    return v;
  endfunction

  function automatic int sat(longint v);
    longint ip = v >>> FRAC_W;
    if (v < 0) return 0;
    if (ip > 255) return 255;
    return int'(ip);
  endfunction

  function automatic longint fx(real r);
    return longint'(r * 65536.0);
  endfunction

  task automatic check_out();
    checks++;
    if (value_o !== OUT_W'(exp_val) || vld_o !== exp_vld) begin
      errors++;
      $display("FAIL %s value=%0d vld=%0b expected value=%0d vld=%0b",
               tag, value_o, vld_o, exp_val, exp_vld);
    end
  endtask

  task automatic cyc(bit we, int sel, longint data, bit st, int stp, bit v);
    wr_en = we; wr_sel = 2'(sel); wr_data = ACC_W'(data);
    start = st; step = 2'(stp); vld = v;
    @(posedge clk);
    if (st) begin
      m_acc = m_sh[0]; m_dx = m_sh[1]; m_dy = m_sh[2];
    end else begin
      case (stp)
        1: m_acc = wrap(m_acc + m_dx);
        2: m_acc = wrap(m_acc - m_dx);
        3: m_acc = wrap(m_acc + m_dy);
        default: ;
      endcase
    end
    if (we && sel < 3) m_sh[sel] = wrap(data);
    exp_val = sat(m_acc);
    exp_vld = v;
    @(negedge clk);
    check_out();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) m_sh[i] = 0;
    repeat (3) @(negedge clk);
    tag = "R1"; exp_val = 0; exp_vld = 0;
    check_out();
    rst_ni = 1;
    @(negedge clk);
    check_out();

    // shadow writes before first start: output stays 0
    tag = "R2";
    cyc(1, 0, fx(10.5), 0, 1, 0);
    cyc(1, 1, fx(1.25), 0, 1, 0);
    cyc(1, 2, fx(-0.5), 0, 3, 0);

    tag = "R3";
    cyc(0, 0, 0, 1, 1, 1);            // step ignored, value 10
    tag = "R4";
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 2, 1);
    cyc(0, 0, 0, 0, 3, 1);
    cyc(0, 0, 0, 0, 3, 1);
    tag = "R9";
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1);
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 2, 1);

    // restage while running; select 3 is dropped
    tag = "R2";
    cyc(1, 0, fx(250.0), 0, 1, 1);
    cyc(1, 1, fx(3.0), 0, 1, 1);
    cyc(1, 2, fx(-4.0), 0, 3, 1);
    cyc(1, 3, fx(77.0), 0, 2, 1);

    tag = "R3";
    cyc(1, 0, fx(100.0), 1, 2, 1);    // loads 250, not 100
    tag = "R6";
    cyc(0, 0, 0, 0, 1, 1);            // 253
    cyc(0, 0, 0, 0, 1, 1);            // 256 -> 255
    cyc(0, 0, 0, 0, 1, 1);            // 259 -> 255
    cyc(0, 0, 0, 0, 0, 1);
    tag = "R8";
    cyc(0, 0, 0, 0, 2, 1);            // 256 -> 255
    cyc(0, 0, 0, 0, 2, 1);            // 253

    tag = "R2";
    cyc(1, 0, fx(2.0), 0, 0, 0);
    cyc(1, 1, fx(1.0), 0, 0, 0);
    cyc(1, 2, fx(-1.5), 0, 0, 0);
    tag = "R3";
    cyc(0, 0, 0, 1, 3, 1);            // 2
    tag = "R7";
    cyc(0, 0, 0, 0, 3, 1);            // 0.5
    cyc(0, 0, 0, 0, 3, 1);            // -1.0 -> 0
    cyc(0, 0, 0, 0, 3, 1);            // -2.5 -> 0
    tag = "R8";
    cyc(0, 0, 0, 0, 1, 1);            // -1.5
    cyc(0, 0, 0, 0, 1, 1);            // -0.5
    cyc(0, 0, 0, 0, 1, 1);            // 0.5
    cyc(0, 0, 0, 0, 1, 1);            // 1.5 -> 1
    cyc(0, 0, 0, 0, 1, 1);            // 2.5 -> 2

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule